// File: doc/BRIEF.md
# Subvector Element Swizzle Engine

This block rearranges short sub-vectors that sit packed in a small array of 64-bit registers. A single operation walks VL sub-vectors. For sub-vector i it builds a destination sub-vector of DESTSUBVL elements, and each destination lane j takes the source element picked by a fixed selector sel[j] from inside source sub-vector i. The source and destination sub-vector lengths are set separately and may each be 1 to 4. Selectors may repeat, so the same unit covers swizzles, broadcasts and single-element extraction.

Elements of 8, 16, 32 or 64 bits lie end to end across consecutive registers, starting at a base register. The engine produces one destination sub-vector per clock. It updates the destination registers by read-modify-write, so bytes that no written element covers keep their old value. A test port loads and reads whole registers while the engine is idle. Software sees the operation's progress only through `busy`, a one-cycle `done` pulse, and an `illegal` flag for a selector that points outside the source sub-vector.

Top module: `swz_engine`

## Requirements
- R1: Element k of a region based at register B, with width code w (00=8, 01=16, 10=32, 11=64 bits), lives in register B + k/(8>>w), in bits starting at (k mod (8>>w)) times the element width. For i in 0..VL-1 and j in 0..DESTSUBVL-1, destination element i*DESTSUBVL+j receives source element i*SRCSUBVL+sel[j]. Lane j's selector is in `sel` bits [2j+1:2j].
- R2: Selector values may repeat, and one source element then feeds every lane that names it.
- R3: SRCSUBVL and DESTSUBVL are independent. DESTSUBVL=1 extracts one element per source sub-vector into a packed destination.
- R4: Every byte of a destination register that no written element covers keeps its previous value.
- R5: If any lane j < DESTSUBVL has sel[j] >= SRCSUBVL, the operation writes nothing, `illegal` becomes 1, and `done` pulses one cycle after start. Selectors of lanes j >= DESTSUBVL are not checked. `illegal` holds until the next accepted start.
- R6: With VL=0 the operation writes nothing, leaves `illegal` at 0, and `done` pulses one cycle after start.
- R7: `busy` is 1 from the edge that accepts a start until the last sub-vector is written. `done` is a one-cycle pulse seen VL+1 clock edges after the edge that samples `start`, counting that edge as the first.
- R8: A `start` while `busy` is 1 is ignored. Latency and results are those of the running operation.
- R9: Reset clears every register to 0 and drives `busy`, `done`, `illegal` and `tl_rdata` to 0.
- R10: A test write stores a full 64-bit register. A test read returns the addressed register on `tl_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| src_base | input | 4 | Source base register |
| dst_base | input | 4 | Destination base register |
| src_subvl | input | 3 | Source sub-vector length, 1 to 4 |
| dst_subvl | input | 3 | Destination sub-vector length, 1 to 4 |
| elw | input | 2 | Element width code |
| sel | input | 8 | Four 2-bit lane selectors |
| vl | input | 5 | Number of sub-vectors |
| tl_we | input | 1 | Test write enable (use while idle) |
| tl_addr | input | 4 | Test port register address |
| tl_wdata | input | 64 | Test write data |
| tl_rdata | output | 64 | Registered test read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last accepted start had an out-of-range selector |

## Verification
The bench targets repeated selectors and broadcast from a one-element source. A design that wired lanes by position instead of by selector would leave destination lanes with the wrong bytes. Byte-wide writes that share a register are compared against a byte-level model of the whole array, which catches a write that clobbers neighbouring bytes or one that loses an earlier lane landing in the same register. The bench also sends an out-of-range selector in an active lane and another in an unused lane: a wrong legality check would either corrupt registers or refuse a valid swizzle. VL=0 and a start pulse while busy test the completion timing, which a counter off by one or an engine that restarts would shift.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int FLATW = 16;

  function automatic logic [63:0] elem_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // register step from the base for a flat element index
  function automatic logic [FLATW-1:0] reg_off(input logic [FLATW-1:0] f, input logic [1:0] w);
    return f >> (2'd3 - w);
  endfunction

  // bit position of a flat element inside its register
  function automatic logic [5:0] bit_off(input logic [FLATW-1:0] f, input logic [1:0] w);
    logic [2:0] slot;
    case (w)
      2'd0:    slot = f[2:0];
      2'd1:    slot = {1'b0, f[1:0]};
      2'd2:    slot = {2'b0, f[0]};
      default: slot = 3'd0;
    endcase
    return {3'b0, slot} << (3'd3 + {1'b0, w});
  endfunction
endpackage

// File: rtl/swz_regfile.sv
module swz_regfile #(
  parameter int NREGS  = 16,
  parameter int LANES  = 4,
  parameter int AW     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_busy,
  input  logic              tl_we,
  input  logic [AW-1:0]     tl_addr,
  input  logic [63:0]       tl_wdata,
  output logic [63:0]       tl_rdata,
  input  logic [AW-1:0]     rd_addr [LANES],
  output logic [63:0]       rd_data [LANES],
  input  logic              wr_en   [LANES],
  input  logic [AW-1:0]     wr_reg  [LANES],
  input  logic [63:0]       wr_mask [LANES],
  input  logic [63:0]       wr_data [LANES]
);
  logic [63:0] mem [NREGS];
  logic [63:0] nxt [NREGS];

  always_comb begin
    for (int j = 0; j < LANES; j++) rd_data[j] = mem[rd_addr[j]];
  end

  // merge all lanes landing in one register so none overwrites another
  always_comb begin
    for (int k = 0; k < NREGS; k++) begin
      nxt[k] = mem[k];
      if (tl_we && !eng_busy && tl_addr == AW'(k)) nxt[k] = tl_wdata;
      for (int j = 0; j < LANES; j++) begin
        if (wr_en[j] && wr_reg[j] == AW'(k))
          nxt[k] = (nxt[k] & ~wr_mask[j]) | wr_data[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREGS; k++) mem[k] <= '0;
      tl_rdata <= '0;
    end else begin
      for (int k = 0; k < NREGS; k++) mem[k] <= nxt[k];
      tl_rdata <= mem[tl_addr];
    end
  end
endmodule

// File: rtl/swz_lane.sv
module swz_lane
  import swz_pkg::*;
#(
  parameter int LANE = 0,
  parameter int AW   = 4,
  parameter int SUBW = 3,
  parameter int SELW = 2,
  parameter int VLW  = 5
) (
  input  logic            en,
  input  logic [VLW-1:0]  idx,
  input  logic [AW-1:0]   sb,
  input  logic [AW-1:0]   db,
  input  logic [SUBW-1:0] ss,
  input  logic [SUBW-1:0] ds,
  input  logic [1:0]      elw,
  input  logic [SELW-1:0] sel,
  output logic [AW-1:0]   src_reg,
  input  logic [63:0]     src_word,
  output logic            wr_en,
  output logic [AW-1:0]   dst_reg,
  output logic [63:0]     wr_mask,
  output logic [63:0]     wr_data
);
  logic [FLATW-1:0] s_flat, d_flat;
  logic [5:0]       s_bit, d_bit;
  logic [63:0]      value;

  always_comb begin
    s_flat  = FLATW'(idx) * FLATW'(ss) + FLATW'(sel);
    d_flat  = FLATW'(idx) * FLATW'(ds) + FLATW'(LANE);
    src_reg = sb + AW'(reg_off(s_flat, elw));
    dst_reg = db + AW'(reg_off(d_flat, elw));
    s_bit   = bit_off(s_flat, elw);
    d_bit   = bit_off(d_flat, elw);
    value   = (src_word >> s_bit) & elem_mask(elw);
    wr_mask = elem_mask(elw) << d_bit;
    wr_data = value << d_bit;
    wr_en   = en && (SUBW'(LANE) < ds);
  end
endmodule

// File: rtl/swz_ctrl.sv
module swz_ctrl #(
  parameter int AW     = 4,
  parameter int SUBW   = 3,
  parameter int SELW   = 2,
  parameter int VLW    = 5,
  parameter int LANES  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [AW-1:0]         src_base,
  input  logic [AW-1:0]         dst_base,
  input  logic [SUBW-1:0]       src_subvl,
  input  logic [SUBW-1:0]       dst_subvl,
  input  logic [1:0]            elw,
  input  logic [LANES*SELW-1:0] sel,
  input  logic [VLW-1:0]        vl,
  output logic                  busy,
  output logic                  done,
  output logic                  illegal,
  output logic [VLW-1:0]        cur,
  output logic [AW-1:0]         sb_q,
  output logic [AW-1:0]         db_q,
  output logic [SUBW-1:0]       ss_q,
  output logic [SUBW-1:0]       ds_q,
  output logic [1:0]            elw_q,
  output logic [LANES*SELW-1:0] sel_q
);
  logic           bad_sel;
  logic [VLW-1:0] vl_q;

  always_comb begin
    bad_sel = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (SUBW'(j) < dst_subvl && SUBW'(sel[j*SELW +: SELW]) >= src_subvl)
        bad_sel = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; illegal <= 1'b0;
      cur <= '0; vl_q <= '0;
      sb_q <= '0; db_q <= '0; ss_q <= '0; ds_q <= '0; elw_q <= '0; sel_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sb_q <= src_base; db_q <= dst_base; ss_q <= src_subvl; ds_q <= dst_subvl;
          elw_q <= elw; sel_q <= sel; vl_q <= vl; cur <= '0;
          illegal <= bad_sel;
          if (bad_sel || vl == '0) done <= 1'b1;
          else                     busy <= 1'b1;
        end
      end else if (cur == vl_q - 1'b1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cur <= cur + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swz_engine.sv
module swz_engine #(
  parameter int NREGS = 16,
  parameter int LANES = 4,
  parameter int VLW   = 5,
  parameter int AW    = $clog2(NREGS),
  parameter int SELW  = $clog2(LANES),
  parameter int SUBW  = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [AW-1:0]         src_base,
  input  logic [AW-1:0]         dst_base,
  input  logic [SUBW-1:0]       src_subvl,
  input  logic [SUBW-1:0]       dst_subvl,
  input  logic [1:0]            elw,
  input  logic [LANES*SELW-1:0] sel,
  input  logic [VLW-1:0]        vl,
  input  logic                  tl_we,
  input  logic [AW-1:0]         tl_addr,
  input  logic [63:0]           tl_wdata,
  output logic [63:0]           tl_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  illegal
);
  logic [VLW-1:0]        cur;
  logic [AW-1:0]         sb_q, db_q;
  logic [SUBW-1:0]       ss_q, ds_q;
  logic [1:0]            elw_q;
  logic [LANES*SELW-1:0] sel_q;

  logic [AW-1:0] rd_addr [LANES];
  logic [63:0]   rd_data [LANES];
  logic          wr_en   [LANES];
  logic [AW-1:0] wr_reg  [LANES];
  logic [63:0]   wr_mask [LANES];
  logic [63:0]   wr_data [LANES];

  swz_ctrl #(.AW(AW), .SUBW(SUBW), .SELW(SELW), .VLW(VLW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
    .src_subvl(src_subvl), .dst_subvl(dst_subvl), .elw(elw), .sel(sel), .vl(vl),
    .busy(busy), .done(done), .illegal(illegal), .cur(cur),
    .sb_q(sb_q), .db_q(db_q), .ss_q(ss_q), .ds_q(ds_q), .elw_q(elw_q), .sel_q(sel_q)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    swz_lane #(.LANE(j), .AW(AW), .SUBW(SUBW), .SELW(SELW), .VLW(VLW)) u_lane (
      .en(busy), .idx(cur), .sb(sb_q), .db(db_q), .ss(ss_q), .ds(ds_q), .elw(elw_q),
      .sel(sel_q[j*SELW +: SELW]), .src_reg(rd_addr[j]), .src_word(rd_data[j]),
      .wr_en(wr_en[j]), .dst_reg(wr_reg[j]), .wr_mask(wr_mask[j]), .wr_data(wr_data[j])
    );
  end

  swz_regfile #(.NREGS(NREGS), .LANES(LANES), .AW(AW)) u_rf (
    .clk(clk), .rst(rst), .eng_busy(busy), .tl_we(tl_we), .tl_addr(tl_addr),
    .tl_wdata(tl_wdata), .tl_rdata(tl_rdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_mask(wr_mask), .wr_data(wr_data)
  );
endmodule

// File: rtl/swz_engine_chk.sv
module swz_engine_chk #(
  parameter int VLW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           busy,
  input logic           done,
  input logic           illegal
);
  logic [VLW-1:0] vl_l;
  logic [VLW:0]   n;

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_l <= '0; n <= '0;
    end else if (start && !busy) begin
      vl_l <= vl; n <= '0;
    end else if (busy) begin
      n <= n + 1'b1;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_run_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && n == {1'b0, vl_l}));
  assert_illegal_idle_R5: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy);
  assert_empty_done_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0) |=> (done && !busy));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(illegal));
endmodule

bind swz_engine swz_engine_chk #(.VLW(VLW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vl(vl),
  .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/tb_swz_engine.sv
module tb_swz_engine;
  typedef struct packed {
    logic [1:0] elw;
    logic [2:0] ss;
    logic [2:0] ds;
    logic [7:0] sel;
    logic [4:0] vl;
    logic [3:0] sb;
    logic [3:0] db;
  } vec_t;

  // table walked by one loop; selector lane j sits in sel[2j+1:2j]
  localparam vec_t VECS [5] = '{
    '{2'd0, 3'd3, 3'd4, 8'h60, 5'd5, 4'd0, 4'd4},   // u8 swizzle [0,0,2,1]
    '{2'd2, 3'd4, 3'd1, 8'h02, 5'd3, 4'd0, 4'd8},   // u32 extract element 2
    '{2'd1, 3'd2, 3'd3, 8'h11, 5'd7, 4'd2, 4'd10},  // u16 [1,0,1]
    '{2'd3, 3'd4, 3'd4, 8'h1B, 5'd2, 4'd0, 4'd8},   // u64 reverse
    '{2'd0, 3'd1, 3'd4, 8'h00, 5'd6, 4'd1, 4'd12}   // u8 broadcast
  };
  localparam string VTAG [5] = '{"R1 R2 R4", "R3 R4", "R1 R4", "R1", "R2 R3 R4"};

  logic clk = 0, rst = 1, start = 0, tl_we = 0;
  logic [3:0] src_base = 0, dst_base = 0, tl_addr = 0;
  logic [2:0] src_subvl = 1, dst_subvl = 1;
  logic [1:0] elw = 0;
  logic [7:0] sel = 0;
  logic [4:0] vl = 0;
  logic [63:0] tl_wdata = 0, tl_rdata;
  logic busy, done, illegal;
  logic [63:0] mirror [16];
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  swz_engine dut (.clk(clk), .rst(rst), .start(start), .src_base(src_base),
    .dst_base(dst_base), .src_subvl(src_subvl), .dst_subvl(dst_subvl), .elw(elw),
    .sel(sel), .vl(vl), .tl_we(tl_we), .tl_addr(tl_addr), .tl_wdata(tl_wdata),
    .tl_rdata(tl_rdata), .busy(busy), .done(done), .illegal(illegal));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_all(input int seed);
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 8; b++) mirror[k][b*8 +: 8] = 8'(seed + k * 16 + b * 3);
      @(negedge clk); tl_we = 1; tl_addr = 4'(k); tl_wdata = mirror[k];
    end
    @(negedge clk); tl_we = 0;
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); tl_addr = 4'(k);
      @(negedge clk); check($sformatf("%s reg %0d", req, k), tl_rdata, mirror[k]);
    end
  endtask

  function automatic logic [63:0] get_el(input int base, input int idx, input int w);
    logic [63:0] v = '0;
    int nb = 1 << w;
    for (int b = 0; b < nb; b++) begin
      int a = base * 8 + idx * nb + b;
      v[b*8 +: 8] = mirror[a / 8][(a % 8) * 8 +: 8];
    end
    return v;
  endfunction

  task automatic put_el(input int base, input int idx, input int w, input logic [63:0] v);
    int nb = 1 << w;
    for (int b = 0; b < nb; b++) begin
      int a = base * 8 + idx * nb + b;
      mirror[a / 8][(a % 8) * 8 +: 8] = v[b*8 +: 8];
    end
  endtask

  task automatic model(input vec_t v);
    for (int i = 0; i < int'(v.vl); i++)
      for (int j = 0; j < int'(v.ds); j++)
        put_el(v.db, i * v.ds + j, v.elw,
               get_el(v.sb, i * v.ss + int'(v.sel[j*2 +: 2]), v.elw));
  endtask

  task automatic drive(input vec_t v);
    elw = v.elw; src_subvl = v.ss; dst_subvl = v.ds; sel = v.sel;
    vl = v.vl; src_base = v.sb; dst_base = v.db;
  endtask

  // returns edges from the start-sampling edge to the one after which done is seen
  task automatic run_op(input vec_t v, output int lat, output logic ill, output logic bsy);
    @(negedge clk); drive(v); start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    lat = 1; bsy = busy;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    ill = illegal;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int lat; logic ill, bsy;
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9 busy", 64'(busy), 64'd0);
    check("R9 done", 64'(done), 64'd0);
    check("R9 illegal", 64'(illegal), 64'd0);
    check("R9 tl_rdata", tl_rdata, 64'd0);
    @(negedge clk); tl_addr = 4'd3;
    @(negedge clk); check("R9 reg cleared", tl_rdata, 64'd0);

    // R10 test write then read one clock later
    @(negedge clk); tl_we = 1; tl_addr = 4'd5; tl_wdata = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk); tl_we = 0;
    @(negedge clk); check("R10 test readback", tl_rdata, 64'hDEAD_BEEF_0123_4567);

    // table of swizzles
    foreach (VECS[n]) begin
      load_all(n * 37 + 5);
      run_op(VECS[n], lat, ill, bsy);
      check($sformatf("R7 latency vec %0d", n), 64'(lat), 64'(VECS[n].vl) + 1);
      check($sformatf("R7 busy vec %0d", n), 64'(bsy), 64'd1);
      check($sformatf("R5 illegal clear vec %0d", n), 64'(ill), 64'd0);
      model(VECS[n]);
      check_regs($sformatf("%s vec %0d", VTAG[n], n));
    end

    // R5 selector 3 in active lane 1 with SRCSUBVL 3
    load_all(11);
    v = '{2'd0, 3'd3, 3'd2, 8'h0C, 5'd4, 4'd0, 4'd4};
    run_op(v, lat, ill, bsy);
    check("R5 illegal latency", 64'(lat), 64'd1);
    check("R5 illegal flag", 64'(ill), 64'd1);
    check_regs("R5 no writes");

    // R5 out-of-range selectors only in unused lanes
    v = '{2'd0, 3'd2, 3'd1, 8'hFC, 5'd3, 4'd0, 4'd6};
    run_op(v, lat, ill, bsy);
    check("R5 unused lanes legal", 64'(ill), 64'd0);
    check("R5 unused lanes latency", 64'(lat), 64'd4);
    model(v);
    check_regs("R5 unused lanes result");

    // R6 empty operation
    load_all(23);
    v = '{2'd1, 3'd2, 3'd2, 8'h04, 5'd0, 4'd0, 4'd8};
    run_op(v, lat, ill, bsy);
    check("R6 latency", 64'(lat), 64'd1);
    check("R6 illegal", 64'(ill), 64'd0);
    check("R6 busy", 64'(bsy), 64'd0);
    check_regs("R6 no writes");

    // R8 second start while busy must be ignored
    load_all(61);
    @(negedge clk); drive(VECS[0]); start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    @(posedge clk); @(negedge clk);
    vl = 5'd0; dst_base = 4'd0; sel = 8'hFF; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    lat = 3;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R8 latency kept", 64'(lat), 64'd6);
    check("R8 illegal kept", 64'(illegal), 64'd0);
    model(VECS[0]);
    check_regs("R8 result");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule